// File: doc/BRIEF.md
# SM3/SM4 Scalar Crypto Decode-Execute Slice

This slice sits beside the main integer decoder of a processor pipeline and handles the four scalar instructions for the SM3 hash and the SM4 block cipher. Each cycle it may receive one 32-bit instruction word with a valid strobe, the two source operand values, and one enable bit per extension. It compares the word against the four exact encodings. The two SM3 permutations are computed inside the slice from the low 32 bits of the first operand. The two SM4 instructions are passed on combinationally to an external SM4 round step unit, and the 32-bit answer from that unit is taken back in the same cycle.

One register stage follows. It presents the destination index, the sign-extended result, a register-file write enable and an illegal-instruction flag. A word that matches none of the encodings is marked illegal. So is a matching word whose extension is switched off. A write aimed at x0 is dropped. Hazard handling and all other instruction decode are left to the surrounding pipeline.

Top module: `sm_crypto_exec`

## Requirements
- R1: A word with bits[31:20]=0x108, bits[14:12]=001 and bits[6:0]=0010011 (mask 0xFFF0707F, value 0x10801013) is the SM3 P0 permutation when `hash_en` is high. Its 32-bit result is t ^ rotl(t,9) ^ rotl(t,17), where t = rs1_val[31:0].
- R2: The same word with bits[31:20]=0x109 (value 0x10901013) is SM3 P1 when `hash_en` is high. Its result is t ^ rotl(t,15) ^ rotl(t,23).
- R3: Every 32-bit result is sign-extended from bit 31 to XLEN bits on `out_data`.
- R4: When `hash_en` is low, P0 and P1 words raise `out_illegal` and leave `out_we` low.
- R5: The SM4 encryption step matches mask 0x3E00707F with value 0x30000033, and the SM4 key-schedule step matches the same mask with value 0x34000033. When `cipher_en` is high and `in_valid` is high in the same cycle, `step_valid` is high. In that case `step_a`/`step_b` carry rs1_val[31:0]/rs2_val[31:0], `step_bsel` carries bits[31:30], and `step_keysched` is high only for the key-schedule form. One cycle later `out_data` carries `step_res` sign-extended.
- R6: When `cipher_en` is low, the two SM4 words keep `step_valid` low, raise `out_illegal` and leave `out_we` low.
- R7: A valid word that matches none of the four encodings raises `out_illegal`, keeps `out_we` low and gives `out_data` = 0.
- R8: A legal instruction with rd = bits[11:7] = 0 gives `out_we` low and `out_illegal` low. A legal instruction with rd ≠ 0 gives `out_we` high. `out_rd` always carries bits[11:7] of the word.
- R9: Outputs are registered. `out_valid` follows `in_valid` by one clock. While reset is asserted, every output register is zero.
- R10: A cycle with `in_valid` low gives, one clock later, `out_valid`, `out_we` and `out_illegal` low, and `out_rd` and `out_data` zero. It also keeps `step_valid` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | First source operand |
| rs2_val | input | XLEN | Second source operand |
| hash_en | input | 1 | SM3 instructions allowed |
| cipher_en | input | 1 | SM4 instructions allowed |
| step_valid | output | 1 | Request to the SM4 round step unit |
| step_keysched | output | 1 | Request is the key-schedule form (else encryption form) |
| step_bsel | output | 2 | Byte select for the step unit |
| step_a | output | 32 | Accumulator operand to the step unit |
| step_b | output | 32 | Byte-source operand to the step unit |
| step_res | input | 32 | Combinational answer from the step unit |
| out_valid | output | 1 | Registered result slot is occupied |
| out_rd | output | 5 | Destination register index |
| out_data | output | XLEN | Sign-extended result |
| out_we | output | 1 | Register file write enable |
| out_illegal | output | 1 | Illegal-instruction flag |

## Verification
The bench builds the slice with XLEN = 64. At that width the sign extension of R3 shows up as visible upper-word bits, including a directed P1 case whose 32-bit result has bit 31 set. Random operands, rd values that include x0, near-miss words with one bit flipped, and idle cycles are applied under all four enable combinations. A behavioural stand-in for the step unit mixes every forwarded field into its answer, so a wrong operand, byte select or mode reaches `out_data`.

// File: rtl/sm_crypto_exec.sv
module sm_crypto_exec #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic            hash_en,
  input  logic            cipher_en,
  output logic            step_valid,
  output logic            step_keysched,
  output logic [1:0]      step_bsel,
  output logic [31:0]     step_a,
  output logic [31:0]     step_b,
  input  logic [31:0]     step_res,
  output logic            out_valid,
  output logic [4:0]      out_rd,
  output logic [XLEN-1:0] out_data,
  output logic            out_we,
  output logic            out_illegal
);
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] OPC_REG = 7'b0110011;

  logic [31:0] t, p0_val, p1_val, res32;
  logic        hit_p0, hit_p1, hit_ed, hit_ks, legal;
  logic [4:0]  rd;

  assign t  = rs1_val[31:0];
  assign rd = instr[11:7];

  assign hit_p0 = (instr[31:20] == 12'h108) && (instr[14:12] == 3'b001) && (instr[6:0] == OPC_IMM);
  assign hit_p1 = (instr[31:20] == 12'h109) && (instr[14:12] == 3'b001) && (instr[6:0] == OPC_IMM);
  assign hit_ed = (instr[29:25] == 5'b11000) && (instr[14:12] == 3'b000) && (instr[6:0] == OPC_REG);
  assign hit_ks = (instr[29:25] == 5'b11010) && (instr[14:12] == 3'b000) && (instr[6:0] == OPC_REG);

  assign legal = (hash_en && (hit_p0 || hit_p1)) || (cipher_en && (hit_ed || hit_ks));

  assign p0_val = t ^ {t[22:0], t[31:23]} ^ {t[14:0], t[31:15]};
  assign p1_val = t ^ {t[16:0], t[31:17]} ^ {t[8:0],  t[31:9]};

  assign step_valid    = in_valid && cipher_en && (hit_ed || hit_ks);
  assign step_keysched = hit_ks;
  assign step_bsel     = instr[31:30];
  assign step_a        = rs1_val[31:0];
  assign step_b        = rs2_val[31:0];

  always_comb begin
    if (hit_p0)      res32 = p0_val;
    else if (hit_p1) res32 = p1_val;
    else             res32 = step_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_rd      <= '0;
      out_data    <= '0;
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_rd      <= in_valid ? rd : 5'd0;
      out_data    <= (in_valid && legal) ? XLEN'($signed(res32)) : '0;
      out_we      <= in_valid && legal && (rd != 5'd0);
      out_illegal <= in_valid && !legal;
    end
  end
endmodule

module sm_crypto_exec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic            cipher_en,
  input logic            step_valid,
  input logic            out_valid,
  input logic [4:0]      out_rd,
  input logic [XLEN-1:0] out_data,
  input logic            out_we,
  input logic            out_illegal
);
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_we && !out_illegal));
  // R7
  we_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_we && out_illegal));
  // R8
  no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_rd != 5'd0));
  // R3
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[XLEN-1:31] == '0 || out_data[XLEN-1:31] == '1));
  // R6
  step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (cipher_en && in_valid));
  // R5
  step_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && instr[11:7] != 5'd0) |=> (out_we && !out_illegal));
endmodule

bind sm_crypto_exec sm_crypto_exec_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .cipher_en(cipher_en), .step_valid(step_valid), .out_valid(out_valid),
  .out_rd(out_rd), .out_data(out_data), .out_we(out_we), .out_illegal(out_illegal)
);

// File: tb/sm_crypto_exec_test.sv
`timescale 1ns/1ps
module sm_crypto_exec_test;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] rs1_val = '0, rs2_val = '0;
  logic            hash_en = 1'b0, cipher_en = 1'b0;
  logic            step_valid, step_keysched;
  logic [1:0]      step_bsel;
  logic [31:0]     step_a, step_b, step_res;
  logic            out_valid, out_we, out_illegal;
  logic [4:0]      out_rd;
  logic [XLEN-1:0] out_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // behavioural stand-in for the round step unit
  assign step_res = step_a ^ {step_b[7:0], step_b[31:8]} ^ {30'd0, step_bsel}
                    ^ (step_keysched ? 32'hA5A5_A5A5 : 32'h0);

  sm_crypto_exec #(.XLEN(XLEN)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  task automatic apply(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input bit v, input bit he, input bit ce);
    bit p0, p1, ed, ks, legal;
    logic [31:0] r, t, bx;
    logic [63:0] e_data;
    p0 = (w & 32'hFFF0707F) == 32'h10801013;
    p1 = (w & 32'hFFF0707F) == 32'h10901013;
    ed = (w & 32'h3E00707F) == 32'h30000033;
    ks = (w & 32'h3E00707F) == 32'h34000033;
    legal = ((p0 || p1) && he) || ((ed || ks) && ce);
    t = a[31:0];
    bx = b[31:0];
    if (p0)      r = t ^ rotl(t, 9) ^ rotl(t, 17);
    else if (p1) r = t ^ rotl(t, 15) ^ rotl(t, 23);
    else         r = t ^ {bx[7:0], bx[31:8]} ^ {30'd0, w[31:30]} ^ (ks ? 32'hA5A5_A5A5 : 32'h0);
    e_data = (v && legal) ? {{32{r[31]}}, r} : 64'd0;
    in_valid = v; instr = w; rs1_val = a; rs2_val = b; hash_en = he; cipher_en = ce;
    #1;
    // R5 R6 R10
    chk("R5/R6/R10 step_valid", {63'd0, step_valid}, {63'd0, v && (ed || ks) && ce});
    if (step_valid) begin
      chk("R5 step_a", {32'd0, step_a}, {32'd0, t});
      chk("R5 step_b", {32'd0, step_b}, {32'd0, bx});
      chk("R5 step_bsel", {62'd0, step_bsel}, {62'd0, w[31:30]});
      chk("R5 step_keysched", {63'd0, step_keysched}, {63'd0, ks});
    end
    @(negedge clk);
    vectors++;
    // R9 R10
    chk("R9 out_valid", {63'd0, out_valid}, {63'd0, v});
    chk("R8/R10 out_rd", {59'd0, out_rd}, {59'd0, v ? w[11:7] : 5'd0});
    // R1 R2 R3 R5 R7
    chk("R1/R2/R3/R5/R7 out_data", out_data, e_data);
    // R4 R6 R7 R8
    chk("R4/R6/R8 out_we", {63'd0, out_we}, {63'd0, v && legal && w[11:7] != 5'd0});
    chk("R4/R6/R7 out_illegal", {63'd0, out_illegal}, {63'd0, v && !legal});
  endtask

  function automatic logic [31:0] mk(input int kind, input logic [4:0] rd,
                                     input logic [4:0] s1, input logic [4:0] s2,
                                     input logic [1:0] bs);
    case (kind)
      0: return {12'h108, s1, 3'b001, rd, 7'h13};
      1: return {12'h109, s1, 3'b001, rd, 7'h13};
      2: return {bs, 5'b11000, s2, s1, 3'b000, rd, 7'h33};
      default: return {bs, 5'b11010, s2, s1, 3'b000, rd, 7'h33};
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset out_data", out_data, 64'd0);
    chk("R9 reset out_we", {63'd0, out_we}, 64'd0);
    chk("R9 reset out_illegal", {63'd0, out_illegal}, 64'd0);
    chk("R9 reset out_rd", {59'd0, out_rd}, 64'd0);
    rst_n = 1'b1;

    // R1 directed: P0 of 1 gives 0x00020201
    apply(mk(0, 5'd3, 5'd1, 5'd8, 2'd0), 64'd1, 64'd0, 1, 1, 1);
    chk("R1 directed", out_data, 64'h0000_0000_0002_0201);
    // R2 R3 directed: P1 of 0x80000000 gives 0x80404000, sign-extended
    apply(mk(1, 5'd4, 5'd2, 5'd9, 2'd0), 64'h1234_5678_8000_0000, 64'd0, 1, 1, 1);
    chk("R2/R3 directed", out_data, 64'hFFFF_FFFF_8040_4000);
    // R8 directed: x0 destination
    apply(mk(2, 5'd0, 5'd2, 5'd9, 2'd3), 64'hFFFF_FFFF_0000_0001, 64'h55, 1, 1, 1);
    chk("R8 directed we", {63'd0, out_we}, 64'd0);
    // R7 directed: all-zero word
    apply(32'h0, 64'h77, 64'h88, 1, 1, 1);
    chk("R7 directed illegal", {63'd0, out_illegal}, 64'd1);
    // R10 directed: idle cycle with a legal-looking word
    apply(mk(3, 5'd5, 5'd1, 5'd1, 2'd1), 64'h9, 64'h9, 0, 1, 1);

    for (int en = 0; en < 4; en++) begin
      for (int i = 0; i < 200; i++) begin
        int kind = $urandom_range(0, 5);
        logic [4:0] rd = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
        logic [31:0] w = mk(kind % 4, rd, 5'($urandom), 5'($urandom), 2'($urandom));
        logic [63:0] a = {$urandom, $urandom};
        logic [63:0] b = {$urandom, $urandom};
        bit v = ($urandom_range(0, 9) != 0);
        if (kind == 4) w = $urandom;
        if (kind == 5) w[$urandom_range(0, 31)] ^= 1'b1;
        apply(w, a, b, v, en[0], en[1]);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule